// File: doc/BRIEF.md
# Program RAM DMA Strobe Gate with Per-Word Valid Tracking

This block sits between a DMA engine and an on-chip program RAM. That RAM serves either as an instruction cache or as plain program RAM. The block decides whether a DMA transfer aimed at program space actually strobes the memory. In cache mode the cache fill logic owns the RAM's DMA slot, so the block suppresses the memory strobes. It still acknowledges the DMA engine, so the transfer sequence finishes normally without touching memory. In program-RAM mode the strobes pass straight through.

Alongside the gate, the block keeps one valid flag per internal word. A DMA write that lands inside the internal range while in program-RAM mode marks that word as initialized, so the RAM can be preloaded before the cache is enabled. A combinational lookup port lets the cache side read any word's flag. Leaving cache mode never clears the flags. Only an explicit flush command does, and it clears every flag in one cycle. The mode request input is registered, and the block comes out of reset in program-RAM mode with all flags cleared.

Top module: `pram_dma_gate`

## Requirements
- R1: After reset, cache_mode_o is 0 (program-RAM mode), dma_ack_o is 0 and every valid flag reads 0 on the lookup port.
- R2: In program-RAM mode, mem_rd_o equals dma_rd_i and mem_wr_o equals dma_wr_i in the same cycle. mem_int_o is 1 exactly when dma_addr_i is below INT_DEPTH.
- R3: In cache mode, mem_rd_o and mem_wr_o stay 0 whatever the DMA strobes do.
- R4: dma_ack_o is 1 in the cycle after any cycle in which dma_rd_i or dma_wr_i is 1, in either mode. It is 0 after a cycle with neither strobe.
- R5: A DMA write in program-RAM mode to an address below INT_DEPTH sets the valid flag of that word. The flag reads 1 on the lookup port from the next cycle on.
- R6: A DMA write in program-RAM mode at or above INT_DEPTH reaches memory with mem_int_o at 0 and changes no valid flag.
- R7: DMA writes made in cache mode change no valid flag.
- R8: DMA reads change no valid flag in either mode.
- R9: flush_i clears all valid flags by the next cycle. It takes priority over a DMA write in the same cycle.
- R10: Changing from cache mode to program-RAM mode leaves every valid flag unchanged.
- R11: cache_mode_o takes the value of cache_en_i one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cache_en_i | input | 1 | Mode request: 1 selects cache mode, 0 selects program-RAM mode |
| cache_mode_o | output | 1 | Registered mode currently in force |
| dma_addr_i | input | ADDR_W | DMA word address in program space |
| dma_rd_i | input | 1 | DMA read strobe |
| dma_wr_i | input | 1 | DMA write strobe |
| flush_i | input | 1 | Clear all valid flags |
| mem_rd_o | output | 1 | Gated memory read strobe |
| mem_wr_o | output | 1 | Gated memory write strobe |
| mem_int_o | output | 1 | Address falls in the internal RAM range |
| dma_ack_o | output | 1 | Transfer acknowledge, one cycle after a strobe |
| vld_idx_i | input | IDX_W | Word index for the valid lookup |
| vld_o | output | 1 | Valid flag of the word at vld_idx_i |

## Verification
The bench runs with a 64-word internal range. After each phase it sweeps the lookup port across every word and compares the result with its own shadow map. Writes to every third internal address in program-RAM mode show that exactly the targeted words are set, and none of their neighbours. Writes above the range, reads, and cache-mode writes to the unmarked addresses must leave the map untouched, which separates correct gating from a filter that ignores mode or direction. A flush issued together with a write to an unmarked word, followed by an alternate-address refill, shows flush priority and that flags can be set again after a flush.

// File: rtl/pram_dma_pkg.sv
package pram_dma_pkg;
  // True when a word address lands in the on-chip program RAM.
  function automatic logic in_internal(input logic [31:0] addr, input int unsigned depth);
    return addr < depth;
  endfunction

  // A valid flag is set only by a write, outside cache mode, inside the range.
  function automatic logic marks_word(input logic wr, input logic cache_mode, input logic internal);
    return wr && !cache_mode && internal;
  endfunction
endpackage

// File: rtl/pram_strobe_gate.sv
module pram_strobe_gate (
  input  logic cache_mode_i,
  input  logic rd_i,
  input  logic wr_i,
  input  logic internal_i,
  output logic mem_rd_o,
  output logic mem_wr_o,
  output logic set_o
);
  import pram_dma_pkg::*;

  always_comb begin
    mem_rd_o = rd_i && !cache_mode_i;
    mem_wr_o = wr_i && !cache_mode_i;
    set_o    = marks_word(wr_i, cache_mode_i, internal_i);
  end
endmodule

// File: rtl/pram_dma_ack.sv
module pram_dma_ack (
  input  logic clk,
  input  logic rst_n,
  input  logic rd_i,
  input  logic wr_i,
  output logic ack_o
);
  logic ack_q;

  always_ff @(posedge clk) begin
    if (!rst_n) ack_q <= 1'b0;
    else        ack_q <= rd_i || wr_i;
  end

  assign ack_o = ack_q;
endmodule

// File: rtl/pram_valid_array.sv
module pram_valid_array #(
  parameter int DEPTH = 1024,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_i,
  input  logic [IDX_W-1:0] set_idx_i,
  input  logic             clr_all_i,
  input  logic [IDX_W-1:0] look_idx_i,
  output logic             look_o,
  output logic             any_o
);
  logic [DEPTH-1:0] bits_q;

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    always_ff @(posedge clk) begin
      if (!rst_n)                                 bits_q[g] <= 1'b0;
      else if (clr_all_i)                         bits_q[g] <= 1'b0;
      else if (set_i && set_idx_i == IDX_W'(g))   bits_q[g] <= 1'b1;
    end
  end

  assign look_o = bits_q[look_idx_i];
  assign any_o  = |bits_q;
endmodule

// File: rtl/pram_dma_gate.sv
module pram_dma_gate #(
  parameter int ADDR_W    = 16,
  parameter int INT_DEPTH = 1024,
  localparam int IDX_W    = $clog2(INT_DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cache_en_i,
  output logic              cache_mode_o,
  input  logic [ADDR_W-1:0] dma_addr_i,
  input  logic              dma_rd_i,
  input  logic              dma_wr_i,
  input  logic              flush_i,
  output logic              mem_rd_o,
  output logic              mem_wr_o,
  output logic              mem_int_o,
  output logic              dma_ack_o,
  input  logic [IDX_W-1:0]  vld_idx_i,
  output logic              vld_o
);
  import pram_dma_pkg::*;

  logic cache_mode_q;
  logic addr_internal;
  logic valid_set;
  logic vld_any;

  always_ff @(posedge clk) begin
    if (!rst_n) cache_mode_q <= 1'b0;
    else        cache_mode_q <= cache_en_i;
  end

  assign cache_mode_o  = cache_mode_q;
  assign addr_internal = in_internal(32'(dma_addr_i), INT_DEPTH);
  assign mem_int_o     = addr_internal;

  pram_strobe_gate u_gate (
    .cache_mode_i (cache_mode_q),
    .rd_i         (dma_rd_i),
    .wr_i         (dma_wr_i),
    .internal_i   (addr_internal),
    .mem_rd_o     (mem_rd_o),
    .mem_wr_o     (mem_wr_o),
    .set_o        (valid_set)
  );

  pram_dma_ack u_ack (
    .clk   (clk),
    .rst_n (rst_n),
    .rd_i  (dma_rd_i),
    .wr_i  (dma_wr_i),
    .ack_o (dma_ack_o)
  );

  pram_valid_array #(.DEPTH(INT_DEPTH)) u_valid (
    .clk        (clk),
    .rst_n      (rst_n),
    .set_i      (valid_set),
    .set_idx_i  (dma_addr_i[IDX_W-1:0]),
    .clr_all_i  (flush_i),
    .look_idx_i (vld_idx_i),
    .look_o     (vld_o),
    .any_o      (vld_any)
  );
endmodule

// File: rtl/pram_dma_gate_chk.sv
module pram_dma_gate_chk (
  input logic clk,
  input logic rst_n,
  input logic cache_en_i,
  input logic cache_mode_o,
  input logic dma_rd_i,
  input logic dma_wr_i,
  input logic flush_i,
  input logic mem_rd_o,
  input logic mem_wr_o,
  input logic dma_ack_o,
  input logic valid_set,
  input logic vld_any
);
  // R3
  cache_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cache_mode_o |-> (!mem_rd_o && !mem_wr_o));
  // R4
  ack_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_rd_i || dma_wr_i) |=> dma_ack_o);
  // R4
  ack_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!dma_rd_i && !dma_wr_i) |=> !dma_ack_o);
  // R7
  cache_no_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cache_mode_o |-> !valid_set);
  // R5
  mark_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_set && !flush_i) |=> vld_any);
  // R9
  flush_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> !vld_any);
  // R11
  mode_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n && $past(rst_n) |-> cache_mode_o == $past(cache_en_i));
endmodule

bind pram_dma_gate pram_dma_gate_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cache_en_i   (cache_en_i),
  .cache_mode_o (cache_mode_o),
  .dma_rd_i     (dma_rd_i),
  .dma_wr_i     (dma_wr_i),
  .flush_i      (flush_i),
  .mem_rd_o     (mem_rd_o),
  .mem_wr_o     (mem_wr_o),
  .dma_ack_o    (dma_ack_o),
  .valid_set    (valid_set),
  .vld_any      (vld_any)
);

// File: tb/pram_dma_gate_tb.sv
module pram_dma_gate_tb;
  localparam int AW    = 8;
  localparam int DEPTH = 64;
  localparam int IW    = $clog2(DEPTH);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cache_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic rd = 1'b0, wr = 1'b0, flush = 1'b0;
  logic [IW-1:0] vidx = '0;
  logic cache_mode, mrd, mwr, mint, ack, vld;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  bit shadow [DEPTH];

  always #5 clk = ~clk;

  pram_dma_gate #(.ADDR_W(AW), .INT_DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .cache_en_i(cache_en), .cache_mode_o(cache_mode),
    .dma_addr_i(addr), .dma_rd_i(rd), .dma_wr_i(wr), .flush_i(flush),
    .mem_rd_o(mrd), .mem_wr_o(mwr), .mem_int_o(mint), .dma_ack_o(ack),
    .vld_idx_i(vidx), .vld_o(vld)
  );

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic sweep(input string req);
    for (int i = 0; i < DEPTH; i++) begin
      vidx = IW'(i);
      #1;
      check(req, vld, shadow[i]);
    end
  endtask

  // One transfer: strobe for one cycle, then check gating and acknowledge.
  task automatic xfer(input int a, input bit is_wr, input string req);
    @(negedge clk);
    addr = AW'(a); rd = !is_wr; wr = is_wr;
    #1;
    if (cache_mode) begin
      check("R3 rd gated", mrd, 1'b0);
      check("R3 wr gated", mwr, 1'b0);
    end else begin
      check({req, " R2 rd pass"}, mrd, !is_wr);
      check({req, " R2 wr pass"}, mwr, is_wr);
      check({req, " R2 int sel"}, mint, a < DEPTH);
      if (is_wr && a < DEPTH) shadow[a] = 1'b1;
    end
    @(negedge clk);
    rd = 1'b0; wr = 1'b0;
    #1;
    check("R4 ack after strobe", ack, 1'b1);
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) shadow[i] = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R1 mode", cache_mode, 1'b0);
    check("R1 ack", ack, 1'b0);
    sweep("R1 valid clear");

    for (int a = 0; a < DEPTH; a += 3) xfer(a, 1'b1, "R5");
    sweep("R5 marked words");

    @(negedge clk); #1;
    check("R4 idle no ack", ack, 1'b0);

    for (int a = DEPTH; a < 256; a += 7) begin
      xfer(a, 1'b1, "R6");
      check("R6 external sel", mint, 1'b0);
    end
    sweep("R6 no change");

    for (int a = 1; a < 256; a += 5) xfer(a, 1'b0, "R8");
    sweep("R8 reads no change");

    @(negedge clk); cache_en = 1'b1;
    @(negedge clk); #1;
    check("R11 mode enters cache", cache_mode, 1'b1);
    for (int a = 1; a < DEPTH; a += 3) xfer(a, 1'b1, "R7");
    for (int a = 2; a < DEPTH; a += 9) xfer(a, 1'b0, "R8");
    sweep("R7 cache writes no mark");

    @(negedge clk); cache_en = 1'b0;
    @(negedge clk); #1;
    check("R11 mode leaves cache", cache_mode, 1'b0);
    sweep("R10 valid kept on mode exit");

    @(negedge clk);
    flush = 1'b1; wr = 1'b1; addr = AW'(2);
    @(negedge clk);
    flush = 1'b0; wr = 1'b0;
    for (int i = 0; i < DEPTH; i++) shadow[i] = 1'b0;
    sweep("R9 flush clears all");

    for (int a = 1; a < DEPTH; a += 2) xfer(a, 1'b1, "R5");
    sweep("R5 refill after flush");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule